// File: doc/BRIEF.md
# Reset Cause Control Register

This block is a 32-bit register that tells software why the system last came out of reset, and lets software ask for a new reset. The top five bits are flags. The remaining bits always read as zero. The flags are:

- a power-on flag in bit 31;
- two software request flags: a soft power-on request in bit 30 and a soft external-reset request in bit 29;
- two push-button status flags: a button power-on in bit 28 and a button external reset in bit 27.

The block sits on a simple register bus. Its live word is the one with address bit 2 set inside its 8-byte window, which by default starts at 0xF020. When software writes a request bit, the block raises a one-cycle `sys_rst_req` pulse. The system's own reset logic then asserts `rst` back into the block.

The power-on flag is loaded only on the first `rst` after power-up, or on the first `rst` after software has rearmed it with a soft power-on request. Any later `rst` leaves the register exactly as it was. This lets software tell a power-on apart from a soft external reset. A small "already seen" flag replaces a full reset counter.

Top module: `rst_cause_reg`

## Requirements
- R1: Flags sit in bits 31..27 in the order power-on, soft power-on, soft external reset, button power-on, button external reset. Bits 26..0 always read as 0.
- R2: Write data is masked to bits 31..27. Ones written to bits 26..0 change nothing and request no reset.
- R3: Writing 1 to bit 31, 28 or 27 clears that bit. Writing 1 to bit 30 or 29 sets that bit. Writing 0 leaves every bit unchanged, and writing 1 to bit 30 or 29 never clears it.
- R4: The first `rst` after power-up loads the register with 0x80000000. Every later `rst` leaves the register unchanged.
- R5: Writing 1 to bit 30 rearms the block, so the next `rst` loads 0x80000000 again.
- R6: A live-word write with bit 30 or bit 29 set produces `sys_rst_req` high for exactly the one cycle after the write. Any other write produces no pulse.
- R7: Only the word at base+4 is live. A read of base+0 returns 0. Writes to base+0, or to any address outside the window, are ignored.
- R8: When `rst` is high in the same cycle as a write, the write is discarded and no pulse is produced.
- R9: `pwr_up` clears the register to 0, drops `sys_rst_req` and rearms the block, so the following `rst` loads 0x80000000.
- R10: Reads return data one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_up | input | 1 | Power-up indication; synchronous and highest priority |
| rst | input | 1 | System reset input; synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one cycle after `rd_en` |
| sys_rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
The assertions watch several properties on every cycle:

- the low read-data bits stay at zero;
- every request pulse traces back to an accepting live write of a request bit;
- a reset cycle never lets a write through;
- the request flags stay set until a reset;
- the power-on flag rises only out of a reset;
- power-up clears everything.

Some behaviour only the bench's scenarios can show. These are the first-reset versus later-reset history, the rearm by a soft power-on request, the masking of low write bits, and the handling of the dead word and of out-of-window addresses.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned FLAG_N = 5;
  // flag vector order (MSB first): power-on, soft power-on, soft ext, button power-on, button ext
  localparam int unsigned F_POR      = 4;
  localparam int unsigned F_SOFT_POR = 3;
  localparam int unsigned F_SOFT_EXT = 2;
  localparam logic [FLAG_N-1:0] CLR_ON_ONE = 5'b10011;
  localparam logic [FLAG_N-1:0] SET_ON_ONE = 5'b01100;
  localparam logic [FLAG_N-1:0] LOAD_VAL   = 5'b10000;
endpackage

// File: rtl/rcc_decode.sv
module rcc_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              live_wr,
  output logic              live_rd
);
  localparam int unsigned WIN_LSB = 3;
  logic in_win;
  assign in_win  = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
  assign live_wr = wr_en & in_win & addr[2];
  assign live_rd = rd_en & in_win & addr[2];
endmodule

// File: rtl/rcc_flags.sv
module rcc_flags
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              pwr_up,
  input  logic              rst,
  input  logic              live_wr,
  input  logic [FLAG_N-1:0] wflags,
  output logic [FLAG_N-1:0] flags_q,
  output logic              fire
);
  logic seen_q;

  assign fire = live_wr & ~rst & |(wflags & SET_ON_ONE);

  always_ff @(posedge clk) begin
    if (pwr_up) begin
      flags_q <= '0;
      seen_q  <= 1'b0;
    end else if (rst) begin
      if (!seen_q) flags_q <= LOAD_VAL;
      seen_q <= 1'b1;
    end else if (live_wr) begin
      flags_q <= (flags_q & ~(wflags & CLR_ON_ONE)) | (wflags & SET_ON_ONE);
      if (wflags[F_SOFT_POR]) seen_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rcc_pulse.sv
module rcc_pulse (
  input  logic clk,
  input  logic pwr_up,
  input  logic rst,
  input  logic fire,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (pwr_up || rst) req_q <= 1'b0;
    else               req_q <= fire;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input  logic              clk,
  input  logic              pwr_up,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sys_rst_req
);
  localparam int unsigned PAD_W = DATA_W - FLAG_N;

  logic              live_wr, live_rd, fire;
  logic [FLAG_N-1:0] flags;

  rcc_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .live_wr(live_wr), .live_rd(live_rd)
  );

  rcc_flags u_flags (
    .clk(clk), .pwr_up(pwr_up), .rst(rst), .live_wr(live_wr),
    .wflags(wdata[DATA_W-1 -: FLAG_N]), .flags_q(flags), .fire(fire)
  );

  rcc_pulse u_pulse (
    .clk(clk), .pwr_up(pwr_up), .rst(rst), .fire(fire), .req_q(sys_rst_req)
  );

  always_ff @(posedge clk) begin
    if (pwr_up)       rdata <= '0;
    else if (live_rd) rdata <= {flags, {PAD_W{1'b0}}};
    else              rdata <= '0;
  end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input logic              clk,
  input logic              pwr_up,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              sys_rst_req,
  input logic [4:0]        flags
);
  localparam logic [ADDR_W-1:0] LIVE = BASE | 4;
  logic req_write;
  assign req_write = wr_en && (addr[ADDR_W-1:2] == LIVE[ADDR_W-1:2])
                     && (wdata[DATA_W-2] || wdata[DATA_W-3]);

  p_low_zero_r1: assert property (@(posedge clk) disable iff (pwr_up)
    rdata[DATA_W-6:0] == '0);

  p_req_cause_r6: assert property (@(posedge clk) disable iff (pwr_up)
    sys_rst_req |-> $past(req_write && !rst));

  p_rst_blocks_r8: assert property (@(posedge clk) disable iff (pwr_up)
    rst |=> !sys_rst_req);

  p_req_sticky_r3: assert property (@(posedge clk) disable iff (pwr_up)
    (flags[3] && !rst) |=> flags[3]);

  p_por_rise_r4: assert property (@(posedge clk) disable iff (pwr_up)
    $rose(flags[4]) |-> $past(rst));

  p_pwrup_clear_r9: assert property (@(posedge clk) disable iff (rst)
    pwr_up |=> (flags == '0 && !sys_rst_req && rdata == '0));
endmodule

bind rst_cause_reg rcc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_chk (
  .clk(clk), .pwr_up(pwr_up), .rst(rst), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req), .flags(flags)
);

// File: tb/tb_rst_cause_reg.sv
module tb_rst_cause_reg;
  logic        clk = 1'b0;
  logic        pwr_up = 1'b1;
  logic        rst = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        sys_rst_req;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rst_cause_reg dut (
    .clk(clk), .pwr_up(pwr_up), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [31:0] exp);
    logic [31:0] v;
    do_read(16'hF024, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check(sys_rst_req === 1'b0, "R4 no request after reset", {31'b0, sys_rst_req}, 0);
    expect_reg("R4 first reset loads power-on flag", 32'h8000_0000);
    do_read(16'hF020, v);
    check(v === 0, "R7 dead word reads zero", v, 0);
  endtask

  task automatic t_mask();
    do_write(16'hF024, 32'h07FF_FFFF);
    check(sys_rst_req === 1'b0, "R2 low bits give no request", {31'b0, sys_rst_req}, 0);
    expect_reg("R2 low bits masked (R1 zeros)", 32'h8000_0000);
  endtask

  task automatic t_dead_word();
    do_write(16'hF020, 32'hFFFF_FFFF);
    check(sys_rst_req === 1'b0, "R7 dead word write no request", {31'b0, sys_rst_req}, 0);
    expect_reg("R7 dead word write ignored", 32'h8000_0000);
    do_write(16'hF02C, 32'hFFFF_FFFF);
    check(sys_rst_req === 1'b0, "R7 outside window no request", {31'b0, sys_rst_req}, 0);
    expect_reg("R7 outside window ignored", 32'h8000_0000);
  endtask

  task automatic t_w1c();
    do_write(16'hF024, 32'h0000_0000);
    expect_reg("R3 writing zero keeps bits", 32'h8000_0000);
    do_write(16'hF024, 32'h8000_0000);
    expect_reg("R3 power-on flag cleared by one", 32'h0000_0000);
  endtask

  task automatic t_soft_ext();
    do_write(16'hF024, 32'h2000_0000);
    check(sys_rst_req === 1'b1, "R6 pulse in cycle after write", {31'b0, sys_rst_req}, 1);
    @(negedge clk);
    check(sys_rst_req === 1'b0, "R6 pulse lasts one cycle", {31'b0, sys_rst_req}, 0);
    expect_reg("R3 soft external flag set", 32'h2000_0000);
    pulse_rst();
    expect_reg("R4 later reset leaves register", 32'h2000_0000);
    do_write(16'hF024, 32'h2000_0000);
    expect_reg("R3 set bit not cleared by one", 32'h2000_0000);
  endtask

  task automatic t_rst_priority();
    @(negedge clk); rst = 1'b1; wr_en = 1'b1; addr = 16'hF024; wdata = 32'h4000_0000;
    @(negedge clk); rst = 1'b0; wr_en = 1'b0; wdata = '0;
    check(sys_rst_req === 1'b0, "R8 reset discards write pulse", {31'b0, sys_rst_req}, 0);
    expect_reg("R8 reset discards write", 32'h2000_0000);
    pulse_rst();
    expect_reg("R8 discarded write did not rearm", 32'h2000_0000);
  endtask

  task automatic t_soft_por();
    do_write(16'hF024, 32'h4000_0000);
    check(sys_rst_req === 1'b1, "R6 soft power-on pulse", {31'b0, sys_rst_req}, 1);
    expect_reg("R3 soft power-on flag set", 32'h6000_0000);
    pulse_rst();
    expect_reg("R5 rearmed reset loads power-on", 32'h8000_0000);
    do_write(16'hF024, 32'h8000_0000);
    pulse_rst();
    expect_reg("R4 reset after rearm used leaves register", 32'h0000_0000);
  endtask

  task automatic t_both();
    do_write(16'hF024, 32'h6000_0000);
    check(sys_rst_req === 1'b1, "R6 both bits one pulse", {31'b0, sys_rst_req}, 1);
    @(negedge clk);
    check(sys_rst_req === 1'b0, "R6 both bits single cycle", {31'b0, sys_rst_req}, 0);
    expect_reg("R3 both request flags set", 32'h6000_0000);
    pulse_rst();
    expect_reg("R5 rearm with both bits", 32'h8000_0000);
  endtask

  task automatic t_pwrup();
    logic [31:0] v;
    do_write(16'hF024, 32'h2000_0000);
    @(negedge clk); pwr_up = 1'b1;
    @(negedge clk); pwr_up = 1'b0;
    check(sys_rst_req === 1'b0, "R9 power-up drops request", {31'b0, sys_rst_req}, 0);
    expect_reg("R9 power-up clears register", 32'h0000_0000);
    pulse_rst();
    expect_reg("R9 reset after power-up loads power-on", 32'h8000_0000);
    @(negedge clk); rd_en = 1'b1; addr = 16'hF024;
    v = rdata;
    check(v === 0, "R10 no data before read latency", v, 0);
    @(negedge clk); rd_en = 1'b0;
    check(rdata === 32'h8000_0000, "R10 data one cycle after read", rdata, 32'h8000_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    pwr_up = 1'b0;
    pulse_rst();
    t_reset_state();
    t_mask();
    t_dead_word();
    t_w1c();
    t_soft_ext();
    t_rst_priority();
    t_soft_por();
    t_both();
    t_pwrup();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule